// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block times the host side of programmed-I/O data transfers on a two-channel IDE host. Each transfer passes through three phases. In the address-setup phase the address is valid and the strobe is idle. In the active phase the read or write strobe is asserted. In the recovery phase both are released. The number of clocks in each phase comes from per-drive timing bytes. A host programs those bytes through a small index/data byte port.

The primary channel has its own timing bytes for drive 0 and for drive 1. The secondary channel has a single timing set that both of its drives use, so software must program it with the slower timings of the pair. A separate command-timing byte sets the active and recovery counts for command-block accesses. The reset state of every timing byte is zero, and zero selects the slowest timing in each field.

A request is accepted only while the generator is idle. The timing for the transfer is captured when the request is accepted. When the recovery phase ends, a one-clock done pulse follows.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset every timing byte reads back 0x00, addr_valid, both strobes, done and busy are low, and a transfer runs with setup 4, active 16 and recovery 16 clocks.
- R2: Bits [7:6] of a drive's address-timing byte select the setup length: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5. Bits [5:0] do not affect the timing.
- R3: In a read/write timing byte, bits [7:4] are the active count and bits [3:0] are the recovery count. A nibble value of 0 means 16 clocks.
- R4: The active phase is never shorter than 2 clocks, so an active nibble of 1 gives 2 clocks.
- R5: When late_rev is 1, the recovery phase lasts the decoded recovery count plus one clock.
- R6: Primary channel (chan 0) drive 0 uses address-timing index 0x20 and read/write-timing index 0x24. Drive 1 uses index 0x21 and index 0x25.
- R7: Both drives of the secondary channel (chan 1) use the shared indices 0x22 (address timing) and 0x26 (read/write timing).
- R8: A command access (req_cmd=1) takes its setup from the selected drive's address-timing byte and its active and recovery counts from the command-timing byte at index 0x28. That byte uses the same nibble format as R3, so 0x00 selects 16/16.
- R9: A write at host offset 0 sets the index register. A write at offset 4 stores the full byte into the register the index selects. Reading offset 0 returns the index. Reading offset 4 returns the selected register, or 0x00 for an unmapped index. Any other offset reads 0x00 and ignores writes.
- R10: A request is accepted only when busy is low, and a request made while busy is ignored. done is high for exactly one clock, in the cycle after the last recovery clock, and the generator is idle again in the cycle after that.
- R11: The strobe is asserted only in the active phase: rd_stb when req_write was 0 and wr_stb when it was 1. addr_valid is high from the first setup clock through the last active clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| late_rev | input | 1 | 1 selects the later silicon behaviour, which adds one recovery clock |
| host_we | input | 1 | Host byte write |
| host_addr | input | 3 | Host port offset (0 = index, 4 = data) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| req | input | 1 | Transfer request |
| req_chan | input | 1 | Channel select (0 primary, 1 secondary) |
| req_drive | input | 1 | Drive select within the channel |
| req_cmd | input | 1 | 1 for a command-block access |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| busy | output | 1 | Transfer in progress |
| addr_valid | output | 1 | Address valid, through setup and active |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The main sweep runs every setup code against all 256 active/recovery nibble pairs. For each transfer it counts the clocks in each phase, so a wrong code mapping, a missing zero-means-sixteen case or a lost minimum-active clamp shows up as a count mismatch. A recovery sweep with late_rev set separates the two silicon behaviours. Transfers with distinct per-slot bytes on each channel, drive and command combination tell a wrong slot selection apart from a wrong decode. A second request made mid-transfer, with the opposite direction, shows whether the design ignores requests while busy.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 5;
    localparam int NSLOT    = 3;
    localparam int SLOT_W   = $clog2(NSLOT);
    localparam int OFS_W    = 3;

    localparam logic [OFS_W-1:0]  OFS_INDEX = 3'd0;
    localparam logic [OFS_W-1:0]  OFS_DATA  = 3'd4;

    localparam logic [BYTE_W-1:0] IDX_ADDR_BASE = 8'h20;
    localparam logic [BYTE_W-1:0] IDX_RW_BASE   = 8'h24;
    localparam logic [BYTE_W-1:0] IDX_CMD       = 8'h28;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } phase_cnt_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        case (code)
            2'b00:   setup_clocks = 5'd4;
            2'b01:   setup_clocks = 5'd2;
            2'b10:   setup_clocks = 5'd3;
            default: setup_clocks = 5'd5;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] nib_clocks(input logic [3:0] n);
        nib_clocks = (n == 4'd0) ? 5'd16 : {1'b0, n};
    endfunction

    function automatic logic [CNT_W-1:0] active_clocks(input logic [3:0] n);
        active_clocks = (n == 4'd1) ? 5'd2 : nib_clocks(n);
    endfunction

    function automatic logic [CNT_W-1:0] recov_clocks(input logic [3:0] n,
                                                      input logic late);
        recov_clocks = nib_clocks(n) + {4'd0, late};
    endfunction

endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_timing_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          host_we,
    input  logic [OFS_W-1:0]              host_addr,
    input  logic [BYTE_W-1:0]             host_wdata,
    output logic [BYTE_W-1:0]             host_rdata,
    output logic [NSLOT-1:0][BYTE_W-1:0]  addr_tim,
    output logic [NSLOT-1:0][BYTE_W-1:0]  rw_tim,
    output logic [BYTE_W-1:0]             cmd_tim
);

    logic [BYTE_W-1:0] idx_q;
    logic              data_we;

    assign data_we = host_we && (host_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (host_we && host_addr == OFS_INDEX)
            idx_q <= host_wdata;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_tim[s] <= '0;
                rw_tim[s]   <= '0;
            end else if (data_we) begin
                if (idx_q == IDX_ADDR_BASE + BYTE_W'(s))
                    addr_tim[s] <= host_wdata;
                if (idx_q == IDX_RW_BASE + BYTE_W'(s))
                    rw_tim[s] <= host_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmd_tim <= '0;
        else if (data_we && idx_q == IDX_CMD)
            cmd_tim <= host_wdata;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_INDEX) begin
            host_rdata = idx_q;
        end else if (host_addr == OFS_DATA) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (idx_q == IDX_ADDR_BASE + BYTE_W'(s)) host_rdata = addr_tim[s];
                if (idx_q == IDX_RW_BASE + BYTE_W'(s))   host_rdata = rw_tim[s];
            end
            if (idx_q == IDX_CMD) host_rdata = cmd_tim;
        end
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_write,
    input  phase_cnt_t cnt_in,
    output logic       busy,
    output logic       addr_valid,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic       done
);

    phase_e           ph;
    phase_cnt_t       lat_q;
    logic [CNT_W-1:0] left_q;
    logic             dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            lat_q  <= '0;
            left_q <= '0;
            dir_q  <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (req) begin
                    ph     <= PH_SETUP;
                    lat_q  <= cnt_in;
                    left_q <= cnt_in.setup - 5'd1;
                    dir_q  <= req_write;
                end
                PH_SETUP: if (left_q == '0) begin
                    ph     <= PH_ACTIVE;
                    left_q <= lat_q.active - 5'd1;
                end else begin
                    left_q <= left_q - 5'd1;
                end
                PH_ACTIVE: if (left_q == '0) begin
                    ph     <= PH_RECOV;
                    left_q <= lat_q.recov - 5'd1;
                end else begin
                    left_q <= left_q - 5'd1;
                end
                PH_RECOV: if (left_q == '0)
                    ph <= PH_DONE;
                else
                    left_q <= left_q - 5'd1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (ph != PH_IDLE);
    assign addr_valid = (ph == PH_SETUP) || (ph == PH_ACTIVE);
    assign rd_stb     = (ph == PH_ACTIVE) && !dir_q;
    assign wr_stb     = (ph == PH_ACTIVE) &&  dir_q;
    assign done       = (ph == PH_DONE);

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
    import pio_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        late_rev,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        req,
    input  logic        req_chan,
    input  logic        req_drive,
    input  logic        req_cmd,
    input  logic        req_write,
    output logic        busy,
    output logic        addr_valid,
    output logic        rd_stb,
    output logic        wr_stb,
    output logic        done
);

    logic [NSLOT-1:0][BYTE_W-1:0] addr_tim;
    logic [NSLOT-1:0][BYTE_W-1:0] rw_tim;
    logic [BYTE_W-1:0]            cmd_tim;
    logic [SLOT_W-1:0]            slot;
    logic [BYTE_W-1:0]            at_sel;
    logic [BYTE_W-1:0]            rw_sel;
    phase_cnt_t                   cnt;

    pio_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .addr_tim   (addr_tim),
        .rw_tim     (rw_tim),
        .cmd_tim    (cmd_tim)
    );

    // The secondary channel maps both drives onto its one shared slot.
    assign slot   = req_chan ? SLOT_W'(NSLOT - 1) : SLOT_W'(req_drive);
    assign at_sel = addr_tim[slot];
    assign rw_sel = req_cmd ? cmd_tim : rw_tim[slot];

    always_comb begin
        cnt.setup  = setup_clocks(at_sel[7:6]);
        cnt.active = active_clocks(rw_sel[7:4]);
        cnt.recov  = recov_clocks(rw_sel[3:0], late_rev);
    end

    pio_phase_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_write  (req_write),
        .cnt_in     (cnt),
        .busy       (busy),
        .addr_valid (addr_valid),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .done       (done)
    );

endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker (
    input logic clk,
    input logic rst,
    input logic req,
    input logic busy,
    input logic addr_valid,
    input logic rd_stb,
    input logic wr_stb,
    input logic done
);

    assert_excl_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    assert_strobe_in_addr_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> addr_valid);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> $past(req && !busy));

    assert_done_after_recov_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy && !addr_valid));

    assert_active_min_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_stb || wr_stb) |=> (rd_stb || wr_stb));

endmodule

bind pio_strobe_timer pio_strobe_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .busy       (busy),
    .addr_valid (addr_valid),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .done       (done)
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       late_rev = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       req = 1'b0, req_chan = 1'b0, req_drive = 1'b0;
    logic       req_cmd = 1'b0, req_write = 1'b0;
    logic       busy, addr_valid, rd_stb, wr_stb, done;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pio_strobe_timer u0 (
        .clk(clk), .rst(rst), .late_rev(late_rev),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .req(req), .req_chan(req_chan), .req_drive(req_drive),
        .req_cmd(req_cmd), .req_write(req_write),
        .busy(busy), .addr_valid(addr_valid), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual cycles=%0d expected finish earlier", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req_tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    function automatic int exp_setup(input int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int exp_act(input int n);
        if (n == 0) return 16;
        if (n == 1) return 2;
        return n;
    endfunction

    function automatic int exp_rec(input int n, input int late);
        return ((n == 0) ? 16 : n) + late;
    endfunction

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        host_wr(3'd0, idx);
        host_wr(3'd4, d);
    endtask

    task automatic get_reg(input logic [7:0] idx, output logic [7:0] d);
        host_wr(3'd0, idx);
        host_addr = 3'd4;
        #1 d = host_rdata;
    endtask

    // Runs one transfer and measures the clocks of each phase at the ports.
    task automatic xfer(input logic ch, input logic dr, input logic cm,
                        input logic wr, output int s, output int a,
                        output int r, output int dir_err, output int tail_ok);
        s = 0; a = 0; r = 0; dir_err = 0; tail_ok = 0;
        @(negedge clk);
        req = 1'b1; req_chan = ch; req_drive = dr; req_cmd = cm; req_write = wr;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 80 && !done; k++) begin
            if (addr_valid && !(rd_stb || wr_stb)) s++;
            else if (rd_stb || wr_stb) a++;
            else if (busy) r++;
            if ((rd_stb && wr) || (wr_stb && !wr)) dir_err++;
            @(negedge clk);
        end
        if (done) begin
            @(negedge clk);
            tail_ok = (!done && !busy) ? 1 : 0;
        end
    endtask

    initial begin
        logic [7:0] d;
        int s, a, r, de, tk;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 addr_valid", addr_valid, 0);
        chk("R1 strobes", rd_stb | wr_stb, 0);
        chk("R1 done", done, 0);
        for (int i = 0; i < 3; i++) begin
            get_reg(8'h20 + 8'(i), d); chk("R1 addr timing reset", d, 0);
            get_reg(8'h24 + 8'(i), d); chk("R1 rw timing reset", d, 0);
        end
        get_reg(8'h28, d); chk("R1 cmd timing reset", d, 0);
        xfer(0, 0, 0, 0, s, a, r, de, tk);
        chk("R1 setup", s, 4); chk("R1 active", a, 16); chk("R1 recov", r, 16);

        // R9: index/data port
        host_wr(3'd0, 8'h21);
        host_addr = 3'd0; #1 chk("R9 index readback", host_rdata, 8'h21);
        set_reg(8'h21, 8'h9B);
        get_reg(8'h21, d); chk("R9 full byte kept", d, 8'h9B);
        set_reg(8'h33, 8'h55);
        get_reg(8'h33, d); chk("R9 unmapped reads 0", d, 0);
        host_wr(3'd2, 8'hFF);
        host_addr = 3'd2; #1 chk("R9 other offset reads 0", host_rdata, 0);
        get_reg(8'h21, d); chk("R9 other offset write ignored", d, 8'h9B);
        set_reg(8'h21, 8'h00);

        // R2 R3 R4 R11: full sweep on primary drive 0
        for (int sc = 0; sc < 4; sc++)
            for (int an = 0; an < 16; an++)
                for (int rn = 0; rn < 16; rn++) begin
                    set_reg(8'h20, 8'((sc << 6) | ((an * 5 + rn) & 8'h3F)));
                    set_reg(8'h24, 8'((an << 4) | rn));
                    xfer(0, 0, 0, 1'((an + rn) & 1), s, a, r, de, tk);
                    chk("R2 setup code", s, exp_setup(sc));
                    chk("R3 R4 active", a, exp_act(an));
                    chk("R3 recovery", r, exp_rec(rn, 0));
                    chk("R11 strobe direction", de, 0);
                    chk("R10 done single pulse", tk, 1);
                end

        // R5: later revision adds a recovery clock
        late_rev = 1'b1;
        for (int rn = 0; rn < 16; rn++) begin
            set_reg(8'h26, 8'h20 | 8'(rn));
            xfer(1, 0, 0, 0, s, a, r, de, tk);
            chk("R5 late recovery", r, exp_rec(rn, 1));
            chk("R5 active unaffected", a, 2);
        end
        late_rev = 1'b0;

        // R6 R7: per-slot selection
        set_reg(8'h20, 8'h40); set_reg(8'h24, 8'h35);
        set_reg(8'h21, 8'h80); set_reg(8'h25, 8'h72);
        set_reg(8'h22, 8'hC0); set_reg(8'h26, 8'h94);
        xfer(0, 0, 0, 0, s, a, r, de, tk);
        chk("R6 drive0 setup", s, 2); chk("R6 drive0 active", a, 3); chk("R6 drive0 recov", r, 5);
        xfer(0, 1, 0, 1, s, a, r, de, tk);
        chk("R6 drive1 setup", s, 3); chk("R6 drive1 active", a, 7); chk("R6 drive1 recov", r, 2);
        for (int dv = 0; dv < 2; dv++) begin
            xfer(1, 1'(dv), 0, 0, s, a, r, de, tk);
            chk("R7 shared setup", s, 5); chk("R7 shared active", a, 9); chk("R7 shared recov", r, 4);
        end

        // R8: command-block accesses
        xfer(0, 1, 1, 0, s, a, r, de, tk);
        chk("R8 cmd setup from drive", s, 3); chk("R8 cmd zero active", a, 16);
        chk("R8 cmd zero recov", r, 16);
        set_reg(8'h28, 8'h43);
        xfer(1, 0, 1, 1, s, a, r, de, tk);
        chk("R8 cmd setup", s, 5); chk("R8 cmd active", a, 4); chk("R8 cmd recov", r, 3);

        // R10: request while busy is ignored
        @(negedge clk);
        req = 1'b1; req_chan = 0; req_drive = 0; req_cmd = 0; req_write = 0;
        @(negedge clk);
        req_write = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 busy request does not change direction", wr_stb, 0);
        chk("R11 read strobe active", rd_stb, 1);
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
        chk("R10 done seen", done, 1);
        repeat (4) begin
            @(negedge clk);
            chk("R10 no second transfer", addr_valid | busy, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule